// File: doc/BRIEF.md
# Multi-Mode Position Counter Core

This block keeps a signed-or-unsigned position count for one axis. An upstream decoder hands it a one-cycle count strobe together with a direction bit, and the core steps a counter of configurable width (32 bits by default) up or down. How a step behaves at the edges of the range is set by a 2-bit mode field. In free-running mode the counter wraps. In single-cycle mode it stops after its first wrap. In range-limit mode it clamps. In modulo-n mode it cycles through the values 0 to N.

A preset register serves as the load value, the clamp ceiling, the modulus N and the compare target. The core raises carry, borrow, compare and index events and keeps them in a status byte. It drives two flag outputs: an active-low event flag, which is either latched or pulsed, and a selectable second flag. Commands for clearing, loading and taking a snapshot of the counter can come from the control side or from the index input. All state is registered on the rising edge of `clk`, and reset is asynchronous and active-low.

Top module: `posctr_core`

## Requirements
- R1: After reset, `cnt_q`, `snap_q` and the preset register are zero. `stat_q` is 8'h08 while `cnt_hold` is low. `ev_flag_n` and `flag_b` are high with `flgb_sel`=00.
- R2: With `mode_sel`=00, each counted strobe adds 1 when `cnt_up`=1 and subtracts 1 when `cnt_up`=0, wrapping modulo 2^W. An up step from all-ones sets carry (status bit 7) and clears sign (bit 0). A down step from zero sets borrow (bit 6) and sets sign.
- R3: With `mode_sel`=01, counting wraps like mode 00. After the first carry or borrow the counter stops and status bit 3 reads 0. A clear or a load lets it count again.
- R4: With `mode_sel`=10, an up strobe at count = preset leaves the count unchanged, and a down strobe at zero leaves it at zero with no borrow. Any other step counts normally.
- R5: With `mode_sel`=11, an up strobe at count = preset gives 0 and sets carry. A down strobe at 0 reloads the preset and sets borrow.
- R6: Compare (status bit 5) is set when a counted step lands on the preset value. In modes 00 and 01 this happens in either direction. In modes 10 and 11 it happens only when counting up.
- R7: Clear beats load, and load beats a count step in the same cycle. Load copies the preset value as it stood before that edge. Snapshot copies the pre-edge count into `snap_q`.
- R8: While `idx_in` is high, status bit 4 is set. `idx_act` picks the extra action: 01 loads, 10 clears, 11 takes a snapshot, 00 does nothing.
- R9: The status byte is {carry, borrow, compare, index, count-enable, 0, direction, sign}. `cmd_clr_stat` clears only bits 7..4, and an event in the same cycle still sets its bit.
- R10: `cmd_set_sign` forces bit 0 to 1 and `cmd_clr_sign` forces it to 0. Clear wins when both are given, and either command overrides a carry or borrow in that cycle.
- R11: While `cnt_hold` is 1, strobes do not change the count and bit 3 reads 0. Bit 1 follows `cnt_up` on every strobe.
- R12: `ev_flag_n` is low when any source enabled in `ev_mask` ([3] carry, [2] borrow, [1] compare, [0] index) is active. With `ev_pulse_mode`=0 the sticky status bits are used. With `ev_pulse_mode`=1 it goes low for one cycle after each event.
- R13: `flag_b` shows sign for `flgb_sel`=01 and direction for `flgb_sel`=10. It is high for 00 and 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_stb | input | 1 | One-cycle count strobe |
| cnt_up | input | 1 | Count direction, 1 = up |
| mode_sel | input | 2 | Limit mode: 00 free, 01 single-cycle, 10 range, 11 modulo-n |
| cnt_hold | input | 1 | 1 disables counting |
| preset_we | input | 1 | Write enable of the preset register |
| preset_din | input | W | Preset write data |
| cmd_clr | input | 1 | Clear counter |
| cmd_load | input | 1 | Load counter from preset |
| cmd_snap | input | 1 | Copy counter to snapshot |
| cmd_clr_stat | input | 1 | Clear sticky status bits |
| cmd_set_sign | input | 1 | Force sign to 1 |
| cmd_clr_sign | input | 1 | Force sign to 0 |
| idx_in | input | 1 | Index, active high, already filtered |
| idx_act | input | 2 | Index action select |
| ev_mask | input | 4 | Event flag source enables |
| ev_pulse_mode | input | 1 | 1 = pulsed event flag, 0 = latched |
| flgb_sel | input | 2 | Second flag select |
| cnt_q | output | W | Counter value |
| snap_q | output | W | Snapshot register |
| stat_q | output | 8 | Status byte |
| ev_flag_n | output | 1 | Active-low event flag |
| flag_b | output | 1 | Second flag |

## Verification
Directed runs drive monotone up and down strobe trains through each of the four modes, with the preset placed at small values and next to all-ones. This separates wrapping, stopping, clamping and modulo reload at both ends of the range. Same-cycle collisions (clear with load, load or snapshot with a strobe, status clear with an event, both sign commands) tell apart the priority orderings. A long random phase mixes modes, presets near both boundaries, index actions and holds, and compares every output each cycle against a behavioural model. This exposes any mismatch in direction-dependent compare or in the event flag modes.

// File: rtl/posctr_pkg.sv
package posctr_pkg;

  typedef enum logic [1:0] {
    MD_FREE    = 2'b00,
    MD_ONESHOT = 2'b01,
    MD_CLAMP   = 2'b10,
    MD_MODN    = 2'b11
  } cmode_e;

  typedef enum logic [1:0] {
    IX_NONE  = 2'b00,
    IX_LOAD  = 2'b01,
    IX_CLEAR = 2'b10,
    IX_SNAP  = 2'b11
  } idxact_e;

  typedef enum logic [1:0] {
    FB_HIGH = 2'b00,
    FB_SIGN = 2'b01,
    FB_DIR  = 2'b10,
    FB_OFF  = 2'b11
  } flgb_e;

  // positions of the event sources, shared by the status byte and the mask
  localparam int EV_CY  = 3;
  localparam int EV_BW  = 2;
  localparam int EV_CMP = 1;
  localparam int EV_IDX = 0;

endpackage

// File: rtl/posctr_step.sv
module posctr_step
  import posctr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] lim,
  input  logic         up,
  input  cmode_e       mode,
  input  logic         go,
  output logic [W-1:0] nxt,
  output logic         cy_ev,
  output logic         bw_ev,
  output logic         cmp_ev
);

  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] ZERO = '0;

  function automatic logic [W-1:0] wrap_inc(input logic [W-1:0] v);
    return v + ONE;
  endfunction

  function automatic logic [W-1:0] wrap_dec(input logic [W-1:0] v);
    return v - ONE;
  endfunction

  logic at_lim, at_zero;
  assign at_lim  = (cnt == lim);
  assign at_zero = (cnt == ZERO);

  always_comb begin
    nxt   = cnt;
    cy_ev = 1'b0;
    bw_ev = 1'b0;
    if (go) begin
      if (up) begin
        if (at_lim && mode == MD_CLAMP) begin
          nxt = cnt;
        end else if (at_lim && mode == MD_MODN) begin
          nxt   = ZERO;
          cy_ev = 1'b1;
        end else begin
          nxt   = wrap_inc(cnt);
          cy_ev = &cnt;
        end
      end else begin
        if (at_zero && mode == MD_CLAMP) begin
          nxt = cnt;
        end else if (at_zero && mode == MD_MODN) begin
          nxt   = lim;
          bw_ev = 1'b1;
        end else begin
          nxt   = wrap_dec(cnt);
          bw_ev = at_zero;
        end
      end
    end
  end

  // compare in both directions for modes 00/01, up only for 10/11
  assign cmp_ev = go && (nxt == lim) && (up || !mode[1]);

endmodule

// File: rtl/posctr_status.sv
module posctr_status
  import posctr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] ev_in,
  input  logic       clr_stat,
  input  logic       set_sign,
  input  logic       clr_sign,
  input  logic       dir_upd,
  input  logic       dir_in,
  input  logic       cen_live,
  input  logic [3:0] ev_mask,
  input  logic       ev_pulse_mode,
  input  flgb_e      flgb_sel,
  output logic [7:0] stat_q,
  output logic       ev_flag_n,
  output logic       flag_b
);

  logic [3:0] sticky_q, pulse_q;
  logic       sign_q, dir_q;

  function automatic logic sign_next(input logic cur, input logic c, input logic s,
                                     input logic cy, input logic bw);
    if (c)       return 1'b0;
    else if (s)  return 1'b1;
    else if (bw) return 1'b1;
    else if (cy) return 1'b0;
    return cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky_q <= '0;
      pulse_q  <= '0;
      sign_q   <= 1'b0;
      dir_q    <= 1'b0;
    end else begin
      sticky_q <= (sticky_q & {4{~clr_stat}}) | ev_in;
      pulse_q  <= ev_in;
      sign_q   <= sign_next(sign_q, clr_sign, set_sign, ev_in[EV_CY], ev_in[EV_BW]);
      if (dir_upd) dir_q <= dir_in;
    end
  end

  assign stat_q = {sticky_q, cen_live, 1'b0, dir_q, sign_q};

  logic [3:0] flag_src;
  assign flag_src  = ev_pulse_mode ? pulse_q : sticky_q;
  assign ev_flag_n = ~|(flag_src & ev_mask);

  always_comb begin
    unique case (flgb_sel)
      FB_SIGN: flag_b = sign_q;
      FB_DIR:  flag_b = dir_q;
      default: flag_b = 1'b1;
    endcase
  end

  // R2
  carry_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_in[EV_CY] |=> stat_q[7]);

  // R9
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stat && ev_in == 4'b0) |=> stat_q[7:4] == 4'b0);

  // R10
  sign_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_sign |=> !stat_q[0]);

endmodule

// File: rtl/posctr_core.sv
module posctr_core
  import posctr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_stb,
  input  logic         cnt_up,
  input  logic [1:0]   mode_sel,
  input  logic         cnt_hold,
  input  logic         preset_we,
  input  logic [W-1:0] preset_din,
  input  logic         cmd_clr,
  input  logic         cmd_load,
  input  logic         cmd_snap,
  input  logic         cmd_clr_stat,
  input  logic         cmd_set_sign,
  input  logic         cmd_clr_sign,
  input  logic         idx_in,
  input  logic [1:0]   idx_act,
  input  logic [3:0]   ev_mask,
  input  logic         ev_pulse_mode,
  input  logic [1:0]   flgb_sel,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] snap_q,
  output logic [7:0]   stat_q,
  output logic         ev_flag_n,
  output logic         flag_b
);

  cmode_e  mode;
  idxact_e iact;
  assign mode = cmode_e'(mode_sel);
  assign iact = idxact_e'(idx_act);

  logic [W-1:0] cnt_r, idr_r, snap_r, step_nxt;
  logic         halted;

  // named internal events
  logic clr_any, ld_any, snap_any, cen, count_go;
  logic cy_ev, bw_ev, cmp_ev;

  assign clr_any  = cmd_clr  || (idx_in && iact == IX_CLEAR);
  assign ld_any   = cmd_load || (idx_in && iact == IX_LOAD);
  assign snap_any = cmd_snap || (idx_in && iact == IX_SNAP);
  assign cen      = !cnt_hold && !halted;
  assign count_go = cnt_stb && cen && !clr_any && !ld_any;

  posctr_step #(.W(W)) u_step (
    .cnt    (cnt_r),
    .lim    (idr_r),
    .up     (cnt_up),
    .mode   (mode),
    .go     (count_go),
    .nxt    (step_nxt),
    .cy_ev  (cy_ev),
    .bw_ev  (bw_ev),
    .cmp_ev (cmp_ev)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_r  <= '0;
      idr_r  <= '0;
      snap_r <= '0;
      halted <= 1'b0;
    end else begin
      if (clr_any)     cnt_r <= '0;
      else if (ld_any) cnt_r <= idr_r;
      else             cnt_r <= step_nxt;
      if (preset_we) idr_r  <= preset_din;
      if (snap_any)  snap_r <= cnt_r;
      if (clr_any || ld_any)
        halted <= 1'b0;
      else if (mode == MD_ONESHOT && (cy_ev || bw_ev))
        halted <= 1'b1;
    end
  end

  logic [3:0] ev_vec;
  assign ev_vec = {cy_ev, bw_ev, cmp_ev, idx_in};

  posctr_status u_stat (
    .clk           (clk),
    .rst_n         (rst_n),
    .ev_in         (ev_vec),
    .clr_stat      (cmd_clr_stat),
    .set_sign      (cmd_set_sign),
    .clr_sign      (cmd_clr_sign),
    .dir_upd       (cnt_stb),
    .dir_in        (cnt_up),
    .cen_live      (cen),
    .ev_mask       (ev_mask),
    .ev_pulse_mode (ev_pulse_mode),
    .flgb_sel      (flgb_e'(flgb_sel)),
    .stat_q        (stat_q),
    .ev_flag_n     (ev_flag_n),
    .flag_b        (flag_b)
  );

  assign cnt_q  = cnt_r;
  assign snap_q = snap_r;

  // R11
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_hold && !clr_any && !ld_any) |=> $stable(cnt_q));

  // R3
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !clr_any && !ld_any) |=> $stable(cnt_q));

  // R4
  clamp_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_go && cnt_up && mode == MD_CLAMP && cnt_q == idr_r) |=> $stable(cnt_q));

  // R5
  modn_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_go && cnt_up && mode == MD_MODN && cnt_q == idr_r) |=> cnt_q == '0);

  // R7
  clear_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_any |=> cnt_q == '0);

endmodule

// File: tb/posctr_core_tb.sv
module posctr_core_tb;

  localparam int W = 32;
  localparam longint MODV = 64'h1_0000_0000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic cnt_stb, cnt_up, cnt_hold, preset_we;
  logic [1:0] mode_sel, idx_act, flgb_sel;
  logic [W-1:0] preset_din;
  logic cmd_clr, cmd_load, cmd_snap, cmd_clr_stat, cmd_set_sign, cmd_clr_sign, idx_in;
  logic [3:0] ev_mask;
  logic ev_pulse_mode;
  logic [W-1:0] cnt_q, snap_q;
  logic [7:0] stat_q;
  logic ev_flag_n, flag_b;

  posctr_core #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_stb(cnt_stb), .cnt_up(cnt_up), .mode_sel(mode_sel),
    .cnt_hold(cnt_hold), .preset_we(preset_we), .preset_din(preset_din), .cmd_clr(cmd_clr),
    .cmd_load(cmd_load), .cmd_snap(cmd_snap), .cmd_clr_stat(cmd_clr_stat),
    .cmd_set_sign(cmd_set_sign), .cmd_clr_sign(cmd_clr_sign), .idx_in(idx_in),
    .idx_act(idx_act), .ev_mask(ev_mask), .ev_pulse_mode(ev_pulse_mode),
    .flgb_sel(flgb_sel), .cnt_q(cnt_q), .snap_q(snap_q), .stat_q(stat_q),
    .ev_flag_n(ev_flag_n), .flag_b(flag_b)
  );

  int total = 0;
  int bad   = 0;

  // behavioural reference state
  longint m_cnt, m_idr, m_snap;
  bit m_halt, m_cy, m_bw, m_cmp, m_idx, m_sign, m_dir;
  bit [3:0] m_pulse;

  task automatic model_reset();
    m_cnt = 0; m_idr = 0; m_snap = 0;
    m_halt = 0; m_cy = 0; m_bw = 0; m_cmp = 0; m_idx = 0; m_sign = 0; m_dir = 0;
    m_pulse = 4'b0;
  endtask

  task automatic lit(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit [7:0] exp_stat();
    bit cen = !cnt_hold && !m_halt;
    return {m_cy, m_bw, m_cmp, m_idx, cen, 1'b0, m_dir, m_sign};
  endfunction

  function automatic bit exp_flag_n();
    bit [3:0] src = ev_pulse_mode ? m_pulse : {m_cy, m_bw, m_cmp, m_idx};
    return (src & ev_mask) == 4'b0;
  endfunction

  function automatic bit exp_flag_b();
    if (flgb_sel == 2'b01) return m_sign;
    if (flgb_sel == 2'b10) return m_dir;
    return 1'b1;
  endfunction

  task automatic compare_all();
    lit("R2 R3 R4 R5 R7 R8 R11 cnt", longint'(cnt_q), m_cnt);
    lit("R7 R8 snap", longint'(snap_q), m_snap);
    lit("R6 R9 R10 R11 stat", longint'(stat_q), longint'(exp_stat()));
    lit("R12 ev_flag_n", longint'(ev_flag_n), longint'(exp_flag_n()));
    lit("R13 flag_b", longint'(flag_b), longint'(exp_flag_b()));
  endtask

  task automatic clear_shots();
    cnt_stb = 0; preset_we = 0; cmd_clr = 0; cmd_load = 0; cmd_snap = 0;
    cmd_clr_stat = 0; cmd_set_sign = 0; cmd_clr_sign = 0; idx_in = 0;
  endtask

  // one clock: model next state, edge, compare at negedge, drop one-shots
  task automatic tick();
    bit clr, ld, snp, go, cy, bw, cmp;
    longint n;
    clr = cmd_clr || (idx_in && idx_act == 2'b10);
    ld  = cmd_load || (idx_in && idx_act == 2'b01);
    snp = cmd_snap || (idx_in && idx_act == 2'b11);
    go  = cnt_stb && !cnt_hold && !m_halt && !clr && !ld;
    n = m_cnt; cy = 0; bw = 0; cmp = 0;
    if (go) begin
      if (cnt_up) begin
        if (mode_sel == 2'b10 && m_cnt == m_idr) n = m_cnt;
        else if (mode_sel == 2'b11 && m_cnt == m_idr) begin n = 0; cy = 1; end
        else begin n = (m_cnt + 1) % MODV; cy = (n == 0); end
      end else begin
        if (mode_sel == 2'b10 && m_cnt == 0) n = 0;
        else if (mode_sel == 2'b11 && m_cnt == 0) begin n = m_idr; bw = 1; end
        else begin n = (m_cnt + MODV - 1) % MODV; bw = (m_cnt == 0); end
      end
      cmp = (n == m_idr) && (cnt_up || mode_sel < 2'b10);
    end
    @(posedge clk);
    if (snp) m_snap = m_cnt;
    if (clr) m_cnt = 0; else if (ld) m_cnt = m_idr; else m_cnt = n;
    if (preset_we) m_idr = longint'(preset_din);
    if (clr || ld) m_halt = 0; else if (mode_sel == 2'b01 && (cy || bw)) m_halt = 1;
    if (cmd_clr_stat) begin m_cy = 0; m_bw = 0; m_cmp = 0; m_idx = 0; end
    m_cy |= cy; m_bw |= bw; m_cmp |= cmp; m_idx |= idx_in;
    m_pulse = {cy, bw, cmp, idx_in};
    if (cmd_clr_sign) m_sign = 0;
    else if (cmd_set_sign) m_sign = 1;
    else if (bw) m_sign = 1;
    else if (cy) m_sign = 0;
    if (cnt_stb) m_dir = cnt_up;
    @(negedge clk);
    compare_all();
    clear_shots();
  endtask

  task automatic steps(int k, bit up);
    for (int i = 0; i < k; i++) begin cnt_stb = 1; cnt_up = up; tick(); end
  endtask

  task automatic set_idr(longint v);
    preset_we = 1; preset_din = W'(v); tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0;
    clear_shots();
    cnt_up = 0; cnt_hold = 0; mode_sel = 0; idx_act = 0; flgb_sel = 0;
    preset_din = '0; ev_mask = 4'b0; ev_pulse_mode = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1 reset state
    lit("R1 cnt", longint'(cnt_q), 0);
    lit("R1 snap", longint'(snap_q), 0);
    lit("R1 stat", longint'(stat_q), 8'h08);
    lit("R1 ev_flag_n", longint'(ev_flag_n), 1);
    lit("R1 flag_b", longint'(flag_b), 1);

    // R2 free-running up counts, compare passes 5
    ev_mask = 4'b0010;
    set_idr(5); cmd_clr = 1; tick();
    steps(7, 1);
    lit("R2 free up", longint'(cnt_q), 7);
    lit("R6 cmp up", longint'(stat_q[5]), 1);
    lit("R12 latched cmp flag", longint'(ev_flag_n), 0);

    // R2 wrap through all-ones both ways
    set_idr(64'hFFFF_FFFE); cmd_load = 1; tick();
    cmd_clr_stat = 1; tick();
    steps(3, 1);
    lit("R2 wrap up", longint'(cnt_q), 1);
    lit("R2 carry", longint'(stat_q[7]), 1);
    lit("R2 sign after carry", longint'(stat_q[0]), 0);
    steps(2, 0);
    lit("R2 wrap down", longint'(cnt_q), 64'hFFFF_FFFF);
    lit("R2 borrow", longint'(stat_q[6]), 1);
    flgb_sel = 2'b01; tick();
    lit("R13 sign on flag_b", longint'(flag_b), 1);

    // R3 single-cycle
    mode_sel = 2'b01;
    set_idr(64'hFFFF_FFFF); cmd_load = 1; tick();
    steps(3, 1);
    lit("R3 stopped", longint'(cnt_q), 0);
    lit("R3 enable bit", longint'(stat_q[3]), 0);
    cmd_clr = 1; tick();
    steps(1, 1);
    lit("R3 restarted", longint'(cnt_q), 1);

    // R4 range-limit
    mode_sel = 2'b10;
    set_idr(3); cmd_clr = 1; tick();
    steps(6, 1);
    lit("R4 top clamp", longint'(cnt_q), 3);
    cmd_clr_stat = 1; tick();
    steps(5, 0);
    lit("R4 bottom clamp", longint'(cnt_q), 0);
    lit("R4 no borrow", longint'(stat_q[6]), 0);

    // R5 modulo-n
    mode_sel = 2'b11; cmd_clr = 1; cmd_clr_stat = 1; tick();
    steps(5, 1);
    lit("R5 mod up", longint'(cnt_q), 1);
    lit("R5 carry", longint'(stat_q[7]), 1);
    steps(3, 0);
    lit("R5 mod down", longint'(cnt_q), 2);
    lit("R5 borrow", longint'(stat_q[6]), 1);

    // R6 direction dependence of compare
    mode_sel = 2'b00;
    set_idr(11); cmd_load = 1; tick();
    set_idr(10); cmd_clr_stat = 1; tick();
    steps(1, 0);
    lit("R6 free down cmp", longint'(stat_q[5]), 1);
    mode_sel = 2'b10;
    set_idr(11); cmd_load = 1; tick();
    set_idr(10); cmd_clr_stat = 1; tick();
    steps(1, 0);
    lit("R6 range down no cmp", longint'(cnt_q), 10);
    lit("R6 range down cmp", longint'(stat_q[5]), 0);

    // R7 priorities and snapshot
    mode_sel = 2'b00;
    cmd_clr = 1; cmd_load = 1; tick();
    lit("R7 clear over load", longint'(cnt_q), 0);
    cmd_load = 1; cnt_stb = 1; cnt_up = 1; tick();
    lit("R7 load over step", longint'(cnt_q), 10);
    cmd_snap = 1; cnt_stb = 1; cnt_up = 1; tick();
    lit("R7 snapshot pre-edge", longint'(snap_q), 10);
    lit("R7 step with snapshot", longint'(cnt_q), 11);

    // R8 index actions
    idx_act = 2'b01; idx_in = 1; tick();
    lit("R8 index load", longint'(cnt_q), 10);
    idx_act = 2'b10; idx_in = 1; tick();
    lit("R8 index clear", longint'(cnt_q), 0);
    steps(1, 1);
    idx_act = 2'b11; idx_in = 1; tick();
    lit("R8 index snap", longint'(snap_q), 1);
    idx_act = 2'b00; cmd_clr_stat = 1; tick();
    idx_in = 1; tick();
    lit("R8 index none keeps count", longint'(cnt_q), 1);
    lit("R8 index bit", longint'(stat_q[4]), 1);

    // R9 status clear
    cmd_clr_stat = 1; tick();
    lit("R9 cleared", longint'(stat_q[7:4]), 0);
    cmd_clr_stat = 1; idx_in = 1; tick();
    lit("R9 event wins clear", longint'(stat_q[4]), 1);

    // R10 sign commands
    cmd_set_sign = 1; tick();
    lit("R10 set", longint'(stat_q[0]), 1);
    cmd_clr_sign = 1; tick();
    lit("R10 clear", longint'(stat_q[0]), 0);
    cmd_set_sign = 1; cmd_clr_sign = 1; tick();
    lit("R10 both", longint'(stat_q[0]), 0);

    // R11 hold
    cnt_hold = 1; steps(3, 1);
    lit("R11 frozen", longint'(cnt_q), 1);
    lit("R11 enable bit", longint'(stat_q[3]), 0);
    cnt_hold = 0;

    // R12 pulsed flag
    ev_mask = 4'b0001; ev_pulse_mode = 1; cmd_clr_stat = 1; tick();
    idx_in = 1; tick();
    lit("R12 pulse low", longint'(ev_flag_n), 0);
    tick();
    lit("R12 pulse ends", longint'(ev_flag_n), 1);
    ev_pulse_mode = 0; tick();
    lit("R12 latched low", longint'(ev_flag_n), 0);
    cmd_clr_stat = 1; tick();
    lit("R12 latched released", longint'(ev_flag_n), 1);

    // R13 direction flag
    flgb_sel = 2'b10; steps(1, 0);
    lit("R13 dir down", longint'(flag_b), 0);
    steps(1, 1);
    lit("R13 dir up", longint'(flag_b), 1);

    // random mix against the model
    for (int i = 0; i < 4000; i++) begin
      if (i % 60 == 0) begin
        mode_sel = 2'($urandom); flgb_sel = 2'($urandom);
        ev_mask = 4'($urandom); ev_pulse_mode = 1'($urandom);
        idx_act = 2'($urandom);
      end
      if (i % 20 == 0) cnt_up = 1'($urandom);
      cnt_stb = ($urandom % 10) < 7;
      if ($urandom % 30 == 0) cnt_up = ~cnt_up;
      cnt_hold = ($urandom % 25) == 0;
      if ($urandom % 40 == 0) begin
        preset_we = 1;
        preset_din = ($urandom % 2) ? W'($urandom % 8) : (32'hFFFF_FFF8 | W'($urandom % 8));
      end
      cmd_clr      = ($urandom % 40) == 0;
      cmd_load     = ($urandom % 30) == 0;
      cmd_snap     = ($urandom % 30) == 0;
      cmd_clr_stat = ($urandom % 20) == 0;
      cmd_set_sign = ($urandom % 60) == 0;
      cmd_clr_sign = ($urandom % 60) == 0;
      idx_in       = ($urandom % 25) == 0;
      tick();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule